// File: doc/BRIEF.md
# Multi-Mode Audio PWM Modulator

The block turns signed 32-bit PCM samples into pairs of pulse-width-modulated signals, one pair per channel, for switching output stages. Each of the eight channels picks its own scheme: complementary two-level (AD), two-level with opposite-signed comparisons (BD), or ternary, where only one side of the pair pulses. The top `CNT_W` bits of each sample become a signed count, which is clamped to a programmable modulation limit between about 87.5% and 99.2% of half scale.

A free-running counter defines a fixed PWM frame of `2^CNT_W` master-clock counts, and every pulse sits centred in its frame. A sample strobe loads new words. The rate-class input sets how many frames make up one sample period: 4 for the 88.2/96 kHz class and 2 for the 176.4/192 kHz class. The channel level moves linearly toward the new sample over that many frames. All widths, modes and routing flags are taken only at frame boundaries. With line-out routing on, the last two channels always run BD to feed a differential filter. Headphone select makes channels 1 and 2 run BD into the headphone amplifier and silences every other channel.

Top module: `audio_pwm_mod`

## Requirements
- R1: During reset and for the whole first frame after reset, every A and B output is low.
- R2: The count d is bits [31:32-CNT_W] of the sample, read as signed. It is clamped to ±M, where M = N/2 − (N/256)·(lim_code_i+1) and N = 2^CNT_W. At defaults (N=512), code 0 gives M=254 and code 15 gives M=224.
- R3: Mode code 0 (AD): A is high for N/2+d counts of the frame and B is its exact complement, so A and B are never high together.
- R4: Mode code 1 (BD): A is high for N/2+d counts and B for N/2−d counts, both centred, so the two overlap for min of the two widths.
- R5: Mode codes 2 and 3 (ternary): for d>0 A is high for 2d counts and B stays low; for d<0 B is high for −2d counts and A stays low; for d=0 both stay low.
- R6: A pulse of width w occupies frame counts floor((N−w)/2) through floor((N−w)/2)+w−1.
- R7: Widths, modes, limit and routing flags change only at frame boundaries. Frame 1 after the frame holding a strobe still shows the level from before the strobe.
- R8: On a strobe, the step is floor((T−L)/OS), with OS=4 when rate_hi_i=0 and OS=2 when rate_hi_i=1. L is the current level and T is the new count. After k boundaries the level is L+k·step for k<OS, and exactly T at k=OS; frame j shows the level after j−1 boundaries.
- R9: With lineout_i high, channels 7 and 8 behave as BD regardless of their mode code, and channels 1–6 follow their own codes.
- R10: With hp_sel_i high, channels 1 and 2 behave as BD regardless of their mode code, and channels 3–8 hold both outputs low.
- R11: Each channel follows its own 2-bit field of mode_i (channel c at bits [2c+1:2c]) and its own 32-bit slice of pcm_i (bits [32c+31:32c]), independent of the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, one PWM count per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_stb_i | input | 1 | One-cycle strobe loading all channel samples |
| pcm_i | input | 256 | Eight signed 32-bit samples, channel c in [32c+31:32c] |
| mode_i | input | 16 | Per-channel scheme code, channel c in [2c+1:2c] |
| lim_code_i | input | 4 | Modulation limit code, 0 = widest |
| rate_hi_i | input | 1 | 0: 88.2/96 kHz class (4 frames per sample), 1: 176.4/192 kHz class (2 frames) |
| lineout_i | input | 1 | Force the last two channels to BD for a differential line output |
| hp_sel_i | input | 1 | Headphone mode: channels 1–2 BD, all others silent |
| pwm_a_o | output | 8 | A output of each channel |
| pwm_b_o | output | 8 | B output of each channel |

## Verification
The bench measures pulse widths, overlaps and first and last high counts over whole frames. A design that confused AD with BD would then show the wrong overlap, and an off-centre pulse would show the wrong edge positions. Full-scale samples of both signs are sent with the narrowest and widest limit codes, which exposes a missing or one-sided clamp. The interpolation tests cover both rate classes and a falling step whose division does not come out even. A design that rounded toward zero, skipped the final snap to the target, or updated within the strobe frame would show a wrong width in one of frames 1 to 5. Routing tests set line-out and headphone select with every channel in AD. A block that left a silenced channel running, or kept a forced channel complementary, would show non-zero widths or zero overlap.

// File: rtl/apm_pkg.sv
package apm_pkg;
  typedef enum logic [1:0] {
    MOD_AD       = 2'd0,
    MOD_BD       = 2'd1,
    MOD_TERN     = 2'd2,
    MOD_TERN_ALT = 2'd3
  } mod_e;
endpackage

// File: rtl/apm_frame_ctr.sv
module apm_frame_ctr #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             frame_start_o
);
  localparam logic [CNT_W-1:0] LAST = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + 1'b1;
  end

  // high in the last count; registers downstream load as the count wraps
  assign frame_start_o = (cnt_o == LAST);
endmodule

// File: rtl/apm_interp.sv
module apm_interp #(
  parameter int CNT_W      = 9,
  parameter int OS_LO_LOG2 = 2,
  parameter int OS_HI_LOG2 = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    stb_i,
  input  logic                    rate_hi_i,
  input  logic signed [CNT_W-1:0] smp_i,
  input  logic                    frame_start_i,
  output logic signed [CNT_W:0]   lvl_o
);
  localparam int LW          = CNT_W + 1;
  localparam int DW          = CNT_W + 2;
  localparam int OS_MAX_LOG2 = (OS_LO_LOG2 > OS_HI_LOG2) ? OS_LO_LOG2 : OS_HI_LOG2;
  localparam int LEFT_W      = OS_MAX_LOG2 + 1;

  logic signed [LW-1:0]  lvl_q, tgt_q, step_q, step_d, lvl_sum;
  logic signed [DW-1:0]  diff;
  logic [LEFT_W-1:0]     left_q;

  always_comb begin
    diff    = $signed({{2{smp_i[CNT_W-1]}}, smp_i}) - $signed({lvl_q[LW-1], lvl_q});
    step_d  = rate_hi_i ? LW'(diff >>> OS_HI_LOG2) : LW'(diff >>> OS_LO_LOG2);
    lvl_sum = lvl_q + step_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      tgt_q  <= '0;
      step_q <= '0;
      left_q <= '0;
    end else if (stb_i) begin
      tgt_q  <= {smp_i[CNT_W-1], smp_i};
      step_q <= step_d;
      left_q <= rate_hi_i ? LEFT_W'(1 << OS_HI_LOG2) : LEFT_W'(1 << OS_LO_LOG2);
    end else if (frame_start_i && left_q != '0) begin
      left_q <= left_q - 1'b1;
      lvl_q  <= (left_q == LEFT_W'(1)) ? tgt_q : lvl_sum;
    end
  end

  assign lvl_o = lvl_q;

  p_left_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= LEFT_W'(1 << OS_MAX_LOG2));

  p_snap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && !stb_i && left_q == LEFT_W'(1)) |=> (lvl_q == $past(tgt_q)));
endmodule

// File: rtl/apm_pulse_gen.sv
module apm_pulse_gen
  import apm_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  frame_start_i,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic signed [CNT_W:0] lvl_i,
  input  logic [1:0]            mode_i,
  input  logic [3:0]            lim_code_i,
  input  logic                  force_bd_i,
  input  logic                  force_off_i,
  output logic                  a_o,
  output logic                  b_o
);
  localparam int N        = 1 << CNT_W;
  localparam int HALF     = N / 2;
  localparam int LIM_STEP = 1 << (CNT_W - 8);
  localparam int WW       = CNT_W + 1;

  mod_e          mode;
  int            d, lim_max, wa, wb;
  logic          off_d, tern_d, inv_d;
  logic [WW-1:0] a_lo_d, a_hi_d, b_lo_d, b_hi_d;
  logic [WW-1:0] a_lo_q, a_hi_q, b_lo_q, b_hi_q;
  logic          inv_q, tern_q, off_q;
  logic [WW-1:0] cw;
  logic          win_a, win_b;

  always_comb begin
    lim_max = HALF - LIM_STEP * (int'(lim_code_i) + 1);
    d = int'(lvl_i);
    if (d > lim_max)       d = lim_max;
    else if (d < -lim_max) d = -lim_max;

    mode = mod_e'(mode_i);
    if (force_bd_i) mode = MOD_BD;
    off_d  = force_off_i;
    tern_d = 1'b0;
    inv_d  = 1'b0;
    wa = 0;
    wb = 0;
    if (!off_d) begin
      unique case (mode)
        MOD_AD: begin wa = HALF + d; inv_d = 1'b1; end
        MOD_BD: begin wa = HALF + d; wb = HALF - d; end
        default: begin
          tern_d = 1'b1;
          wa = (d > 0) ? 2 * d : 0;
          wb = (d < 0) ? -2 * d : 0;
        end
      endcase
    end
    a_lo_d = WW'((N - wa) / 2);
    a_hi_d = WW'((N - wa) / 2 + wa);
    b_lo_d = WW'((N - wb) / 2);
    b_hi_d = WW'((N - wb) / 2 + wb);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_lo_q <= '0; a_hi_q <= '0;
      b_lo_q <= '0; b_hi_q <= '0;
      inv_q  <= 1'b0;
      tern_q <= 1'b0;
      off_q  <= 1'b1;
    end else if (frame_start_i) begin
      a_lo_q <= a_lo_d; a_hi_q <= a_hi_d;
      b_lo_q <= b_lo_d; b_hi_q <= b_hi_d;
      inv_q  <= inv_d;
      tern_q <= tern_d;
      off_q  <= off_d;
    end
  end

  always_comb begin
    cw    = {1'b0, cnt_i};
    win_a = (cw >= a_lo_q) && (cw < a_hi_q);
    win_b = (cw >= b_lo_q) && (cw < b_hi_q);
    a_o   = win_a;
    b_o   = inv_q ? !win_a : win_b;
  end

  p_tern_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tern_q |-> !(a_o && b_o));

  p_off_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q |-> (!a_o && !b_o));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> ($stable(a_lo_q) && $stable(a_hi_q) && $stable(b_lo_q) && $stable(b_hi_q)));
endmodule

// File: rtl/audio_pwm_mod.sv
module audio_pwm_mod #(
  parameter int NCH        = 8,
  parameter int PCM_W      = 32,
  parameter int CNT_W      = 9,
  parameter int OS_LO_LOG2 = 2,
  parameter int OS_HI_LOG2 = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 smp_stb_i,
  input  logic [NCH*PCM_W-1:0] pcm_i,
  input  logic [2*NCH-1:0]     mode_i,
  input  logic [3:0]           lim_code_i,
  input  logic                 rate_hi_i,
  input  logic                 lineout_i,
  input  logic                 hp_sel_i,
  output logic [NCH-1:0]       pwm_a_o,
  output logic [NCH-1:0]       pwm_b_o
);
  logic [CNT_W-1:0] cnt;
  logic             frame_start;
  logic             pcm_lsb_unused;

  assign pcm_lsb_unused = ^pcm_i;

  apm_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_o(cnt), .frame_start_o(frame_start)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam bit IS_HP   = (ch < 2);
    localparam bit IS_LINE = (ch >= NCH - 2);

    logic signed [CNT_W:0] lvl;
    logic                  force_bd, force_off;

    // R9 / R10 routing
    assign force_bd  = (hp_sel_i && IS_HP) || (lineout_i && IS_LINE);
    assign force_off = hp_sel_i && !IS_HP;

    apm_interp #(
      .CNT_W(CNT_W), .OS_LO_LOG2(OS_LO_LOG2), .OS_HI_LOG2(OS_HI_LOG2)
    ) u_interp (
      .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(smp_stb_i), .rate_hi_i(rate_hi_i),
      .smp_i(pcm_i[ch*PCM_W + PCM_W-1 -: CNT_W]), .frame_start_i(frame_start),
      .lvl_o(lvl)
    );

    apm_pulse_gen #(.CNT_W(CNT_W)) u_pg (
      .clk_i(clk_i), .rst_ni(rst_ni), .frame_start_i(frame_start), .cnt_i(cnt),
      .lvl_i(lvl), .mode_i(mode_i[2*ch +: 2]), .lim_code_i(lim_code_i),
      .force_bd_i(force_bd), .force_off_i(force_off),
      .a_o(pwm_a_o[ch]), .b_o(pwm_b_o[ch])
    );
  end
endmodule

// File: tb/audio_pwm_mod_tb_top.sv
module audio_pwm_mod_tb_top;
  localparam int NCH = 8;
  localparam int N   = 512;
  localparam int NV  = 13;

  // {mode, pcm, lim, width A, width B, overlap}; clamp rows (R2): 3, 6, 10, 11
  localparam logic [67:0] VEC [NV] = '{
    {2'd0, 32'h0000_0000, 4'd0,  10'd256, 10'd256, 10'd0},
    {2'd0, 32'h4000_0000, 4'd0,  10'd384, 10'd128, 10'd0},
    {2'd0, 32'hC000_0000, 4'd0,  10'd128, 10'd384, 10'd0},
    {2'd0, 32'h7FFF_FFFF, 4'd0,  10'd510, 10'd2,   10'd0},
    {2'd1, 32'h0000_0000, 4'd0,  10'd256, 10'd256, 10'd256},
    {2'd1, 32'h4000_0000, 4'd0,  10'd384, 10'd128, 10'd128},
    {2'd1, 32'h8000_0000, 4'd15, 10'd32,  10'd480, 10'd32},
    {2'd2, 32'h4000_0000, 4'd0,  10'd256, 10'd0,   10'd0},
    {2'd2, 32'hC000_0000, 4'd0,  10'd0,   10'd256, 10'd0},
    {2'd2, 32'h0000_0000, 4'd0,  10'd0,   10'd0,   10'd0},
    {2'd2, 32'h7FFF_FFFF, 4'd7,  10'd480, 10'd0,   10'd0},
    {2'd0, 32'h8000_0000, 4'd15, 10'd32,  10'd480, 10'd0},
    {2'd3, 32'hC000_0000, 4'd0,  10'd0,   10'd256, 10'd0}
  };

  logic              clk = 0, rst_n = 0, stb = 0;
  logic [NCH*32-1:0] pcm = '0;
  logic [2*NCH-1:0]  mode = '0;
  logic [3:0]        lim = '0;
  logic              rate_hi = 1'b1, lineout = 0, hp = 0;
  logic [NCH-1:0]    pa, pb;

  int errs = 0, checks = 0, edges = 0;
  bit done = 0;
  int ma[NCH], mb[NCH], mov[NCH], fa[NCH], la[NCH], fb[NCH], lb[NCH];

  always #10 clk = ~clk;
  always @(posedge clk) if (rst_n) edges <= edges + 1;

  audio_pwm_mod dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_stb_i(stb), .pcm_i(pcm), .mode_i(mode),
    .lim_code_i(lim), .rate_hi_i(rate_hi), .lineout_i(lineout), .hp_sel_i(hp),
    .pwm_a_o(pa), .pwm_b_o(pb)
  );

  task automatic chk(input bit ok, input string tag, input int ch, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s ch%0d: actual=%0d expected=%0d", tag, ch, act, exp);
    end
  endtask

  task automatic sync_frame();
    @(negedge clk);
    while (edges % N != 0) @(negedge clk);
  endtask

  task automatic measure();
    for (int c = 0; c < NCH; c++) begin
      ma[c] = 0; mb[c] = 0; mov[c] = 0; fa[c] = -1; la[c] = -1; fb[c] = -1; lb[c] = -1;
    end
    for (int i = 0; i < N; i++) begin
      for (int c = 0; c < NCH; c++) begin
        if (pa[c]) begin ma[c]++; if (fa[c] < 0) fa[c] = i; la[c] = i; end
        if (pb[c]) begin mb[c]++; if (fb[c] < 0) fb[c] = i; lb[c] = i; end
        if (pa[c] && pb[c]) mov[c]++;
      end
      @(negedge clk);
    end
  endtask

  // strobe mid-frame, return at the start of the following frame
  task automatic apply(input logic [31:0] v, input logic [2*NCH-1:0] m, input logic [3:0] l,
                       input logic rh, input logic lo, input logic h);
    sync_frame();
    repeat (N/2) @(negedge clk);
    for (int c = 0; c < NCH; c++) pcm[c*32 +: 32] = v;
    mode = m; lim = l; rate_hi = rh; lineout = lo; hp = h;
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    sync_frame();
  endtask

  task automatic settle(input int os);
    repeat (os) measure();
    measure();
  endtask

  task automatic chk_ch(input string tag, input int c, input int wa, input int wb, input int ov);
    chk(ma[c] == wa, {tag, " width A"}, c, ma[c], wa);
    chk(mb[c] == wb, {tag, " width B"}, c, mb[c], wb);
    chk(mov[c] == ov, {tag, " overlap"}, c, mov[c], ov);
  endtask

  function automatic string tag_of(input logic [1:0] m, input logic [31:0] v);
    if (v == 32'h7FFF_FFFF || v == 32'h8000_0000) return "R2";
    if (m == 2'd0) return "R3";
    if (m == 2'd1) return "R4";
    return "R5";
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin : main
    logic [2*NCH-1:0] mix;
    int exp_seq[5];
    repeat (3) @(negedge clk);
    // R1: low during reset
    chk(pa == '0 && pb == '0, "R1 in reset", 0, int'({pa, pb}), 0);
    rst_n = 1'b1;
    measure();
    for (int c = 0; c < NCH; c++) chk_ch("R1 first frame", c, 0, 0, 0);
    // first boundary: level zero, AD
    measure();
    chk_ch("R3 after reset", 0, 256, 256, 0);

    // table walk, 2x class
    for (int v = 0; v < NV; v++) begin
      logic [1:0]  vm;
      logic [31:0] vp;
      vm = VEC[v][67:66];
      vp = VEC[v][65:34];
      apply(vp, {NCH{vm}}, VEC[v][33:30], 1'b1, 1'b0, 1'b0);
      settle(2);
      for (int c = 0; c < NCH; c++)
        chk_ch(tag_of(vm, vp), c, int'(VEC[v][29:20]), int'(VEC[v][19:10]), int'(VEC[v][9:0]));
    end

    // R6 centring, R11 mixed modes, d = -128
    for (int c = 0; c < NCH; c++) mix[2*c +: 2] = 2'(c % 3);
    apply(32'hC000_0000, mix, 4'd0, 1'b1, 1'b0, 1'b0);
    settle(2);
    for (int c = 0; c < NCH; c++) begin
      if (c % 3 == 0)      chk_ch("R11 AD", c, 128, 384, 0);
      else if (c % 3 == 1) chk_ch("R11 BD", c, 128, 384, 128);
      else                 chk_ch("R11 ternary", c, 0, 256, 0);
    end
    chk(fa[0] == 192, "R6 AD first A", 0, fa[0], 192);
    chk(la[0] == 319, "R6 AD last A", 0, la[0], 319);
    chk(fb[2] == 128, "R6 ternary first B", 2, fb[2], 128);
    chk(lb[2] == 383, "R6 ternary last B", 2, lb[2], 383);
    chk(fb[1] == 64 && lb[1] == 447, "R6 BD B span", 1, fb[1], 64);

    // R8 interpolation, 4x class: 0 -> 128
    apply(32'h0000_0000, {NCH{2'd0}}, 4'd0, 1'b1, 1'b0, 1'b0);
    settle(2);
    apply(32'h4000_0000, {NCH{2'd0}}, 4'd0, 1'b0, 1'b0, 1'b0);
    exp_seq = '{256, 288, 320, 352, 384};
    for (int f = 0; f < 5; f++) begin
      measure();
      chk(ma[0] == exp_seq[f], (f == 0) ? "R7 frame1 holds old level" : "R8 ramp 4x", 0, ma[0], exp_seq[f]);
      chk(ma[7] == exp_seq[f], "R8 ramp 4x", 7, ma[7], exp_seq[f]);
    end
    // R8 falling, uneven division floors: 128 -> 3
    apply(32'h0180_0000, {NCH{2'd0}}, 4'd0, 1'b0, 1'b0, 1'b0);
    exp_seq = '{384, 352, 320, 288, 259};
    for (int f = 0; f < 5; f++) begin
      measure();
      chk(ma[0] == exp_seq[f], "R8 floor step", 0, ma[0], exp_seq[f]);
    end
    // R8 2x class: 3 -> 131
    apply(32'h4180_0000, {NCH{2'd0}}, 4'd0, 1'b1, 1'b0, 1'b0);
    exp_seq = '{259, 323, 387, 387, 387};
    for (int f = 0; f < 4; f++) begin
      measure();
      chk(ma[0] == exp_seq[f], "R8 ramp 2x", 0, ma[0], exp_seq[f]);
    end

    // R9 line-out routing, all AD, d = 128
    apply(32'h4000_0000, {NCH{2'd0}}, 4'd0, 1'b1, 1'b1, 1'b0);
    settle(2);
    for (int c = 0; c < NCH; c++)
      if (c >= NCH-2) chk_ch("R9 forced BD", c, 384, 128, 128);
      else            chk_ch("R9 own mode", c, 384, 128, 0);

    // R10 headphone, line-out still high
    apply(32'h4000_0000, {NCH{2'd0}}, 4'd0, 1'b1, 1'b1, 1'b1);
    settle(2);
    for (int c = 0; c < NCH; c++)
      if (c < 2) chk_ch("R10 headphone BD", c, 384, 128, 128);
      else       chk_ch("R10 silenced", c, 0, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule